// File: doc/BRIEF.md
# Microdisplay Panel Strobe Generator

This block produces the control strobes for a small monochrome LCD microdisplay. Its clock is a pixel-rate clock that a PLL outside the block locks to the incoming line rate, 384 periods per line by default. A line-start strobe restarts a position counter inside the line. A field-start strobe restarts a line counter inside the field. From these two counts the block decodes a horizontal start pulse, a vertical clock, a vertical start pulse and a line-polarity inversion level. Every edge falls on a whole pixel-clock period.

The panel only sees strobes inside a fixed window of lines in each field. The inversion level flips once per active line during the back porch. It flips one extra time early in the field, on line 4, but only in the field whose identity matches the first field seen after reset. A sleep request drives the power-down reset output low. Interlaced fields are handled one after another, with no merging between them.

Top module: `lcd_strobe_gen`

## Requirements
- R1: The pixel count restarts on `line_start`. The cycle after a `line_start` edge is position 0. Without a new strobe the count stops at LINE_CLKS-1 and does not wrap.
- R2: `hstart` is high for positions 0 to PULSE_W-1 of every line numbered 22 to 261, and low at every other time.
- R3: `vclk_n` is low for positions 0 to PULSE_W-1 of each even-numbered line from 22 to 260, and high at every other time.
- R4: `vstart_n` is low for positions 0 to PULSE_W-1 of line 22 only, which is one pulse per field.
- R5: A `field_start` edge makes the next line number 1, and it captures `field_id` as the current field. A `line_start` edge without `field_start` adds one to the line number. The line number stops at 2^LINE_W-1, so no window opens again until the next `field_start`.
- R6: `hinv` flips once on every line from 22 to 261. The new level appears when the position reads INV_CLK+1, which is INV_CLK+1 cycles after the `line_start` edge.
- R7: `hinv` also flips on line 4, at the same position, in each field whose `field_id` equals the `field_id` captured at the first `field_start` after reset. In other fields it does not flip on line 4.
- R8: `pdr` equals the inverse of `sleep_req`, delayed by one clock.
- R9: While `rst_n` is low, the outputs read `hstart`=0, `vclk_n`=1, `vstart_n`=1, `hinv`=0 and `pdr`=0. The line number is 0 and the parity capture is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock, locked to the line rate |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle strobe at each line start |
| field_start | input | 1 | One-cycle strobe at each field start |
| field_id | input | 1 | Field identity, sampled on `field_start` |
| sleep_req | input | 1 | Sleep request; high pulls `pdr` low |
| hstart | output | 1 | Horizontal start pulse, active high |
| vclk_n | output | 1 | Vertical clock, active low, on even rows |
| vstart_n | output | 1 | Vertical start pulse, active low, once per field |
| hinv | output | 1 | Line-polarity inversion level |
| pdr | output | 1 | Power-down reset, low while sleeping |

## Verification
The three pulses are decoded without a register from the counters. They are therefore due on the first cycle after the `line_start` edge and last PULSE_W cycles. `hinv` is due INV_CLK+1 cycles after that edge, and `pdr` one cycle after `sleep_req` changes. A model in the bench keeps its own integer position, line, field and inversion state, advances them on each rising edge, and compares all five outputs at every falling edge. Every due cycle is therefore checked where it falls. Counts of vertical start cycles and of inversion flips per field confirm the one-pulse rule, the 240 active flips and the extra flip in the field that matches the captured parity.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

  // Inclusive window test on line or pixel numbers.
  function automatic logic in_range(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // Count position lies within the leading pulse width.
  function automatic logic in_head(input int pos, input int width);
    return pos < width;
  endfunction

endpackage

// File: rtl/lcd_pix_counter.sv
module lcd_pix_counter #(
  parameter int LINE_CLKS = 384,
  parameter int PIX_W     = $clog2(LINE_CLKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  output logic [PIX_W-1:0] pix
);
  localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(LINE_CLKS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)                pix <= '0;
    else if (line_start)       pix <= '0;
    else if (pix != PIX_LAST)  pix <= pix + 1'b1;
  end
endmodule

// File: rtl/lcd_line_tracker.sv
module lcd_line_tracker #(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              field_start,
  input  logic              field_id,
  output logic [LINE_W-1:0] line,
  output logic              fld,
  output logic              par,
  output logic              par_ok
);
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line   <= '0;
      fld    <= 1'b0;
      par    <= 1'b0;
      par_ok <= 1'b0;
    end else if (field_start) begin
      line <= LINE_W'(1);
      fld  <= field_id;
      if (!par_ok) begin
        par    <= field_id;
        par_ok <= 1'b1;
      end
    end else if (line_start && line != LINE_MAX) begin
      line <= line + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_strobe_decode.sv
module lcd_strobe_decode
  import lcd_tg_pkg::*;
#(
  parameter int PIX_W       = 9,
  parameter int LINE_W      = 10,
  parameter int PULSE_W     = 8,
  parameter int FIRST_LINE  = 22,
  parameter int LAST_V_LINE = 260,
  parameter int LAST_H_LINE = 261
) (
  input  logic [PIX_W-1:0]  pix,
  input  logic [LINE_W-1:0] line,
  output logic              hstart,
  output logic              vclk_n,
  output logic              vstart_n
);
  logic head, h_win, v_win;

  always_comb begin
    head     = in_head(int'(pix), PULSE_W);
    h_win    = in_range(int'(line), FIRST_LINE, LAST_H_LINE);
    v_win    = in_range(int'(line), FIRST_LINE, LAST_V_LINE) && !line[0];
    hstart   = head && h_win;
    vclk_n   = !(head && v_win);
    vstart_n = !(head && int'(line) == FIRST_LINE);
  end
endmodule

// File: rtl/lcd_inv_toggler.sv
module lcd_inv_toggler
  import lcd_tg_pkg::*;
#(
  parameter int PIX_W       = 9,
  parameter int LINE_W      = 10,
  parameter int INV_CLK     = 40,
  parameter int FIRST_LINE  = 22,
  parameter int LAST_H_LINE = 261,
  parameter int EXTRA_LINE  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  pix,
  input  logic [LINE_W-1:0] line,
  input  logic              fld,
  input  logic              par,
  input  logic              par_ok,
  output logic              tgl_evt,
  output logic              hinv
);
  logic active_line, extra_line;

  always_comb begin
    active_line = in_range(int'(line), FIRST_LINE, LAST_H_LINE);
    extra_line  = (int'(line) == EXTRA_LINE) && par_ok && (fld == par);
    tgl_evt     = (int'(pix) == INV_CLK) && (active_line || extra_line);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       hinv <= 1'b0;
    else if (tgl_evt) hinv <= ~hinv;
  end
endmodule

// File: rtl/lcd_strobe_gen.sv
module lcd_strobe_gen #(
  parameter int LINE_CLKS   = 384,
  parameter int LINE_W      = 10,
  parameter int PULSE_W     = 8,
  parameter int INV_CLK     = 40,
  parameter int FIRST_LINE  = 22,
  parameter int LAST_V_LINE = 260,
  parameter int LAST_H_LINE = 261,
  parameter int EXTRA_LINE  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_start,
  input  logic field_start,
  input  logic field_id,
  input  logic sleep_req,
  output logic hstart,
  output logic vclk_n,
  output logic vstart_n,
  output logic hinv,
  output logic pdr
);
  localparam int PIX_W = $clog2(LINE_CLKS);

  logic [PIX_W-1:0]  pix_cnt;
  logic [LINE_W-1:0] line_cnt;
  logic              fld, par, par_ok, tgl_evt;

  lcd_pix_counter #(.LINE_CLKS(LINE_CLKS), .PIX_W(PIX_W)) u_pix (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .pix(pix_cnt)
  );

  lcd_line_tracker #(.LINE_W(LINE_W)) u_line (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .field_start(field_start), .field_id(field_id),
    .line(line_cnt), .fld(fld), .par(par), .par_ok(par_ok)
  );

  lcd_strobe_decode #(
    .PIX_W(PIX_W), .LINE_W(LINE_W), .PULSE_W(PULSE_W),
    .FIRST_LINE(FIRST_LINE), .LAST_V_LINE(LAST_V_LINE), .LAST_H_LINE(LAST_H_LINE)
  ) u_dec (
    .pix(pix_cnt), .line(line_cnt),
    .hstart(hstart), .vclk_n(vclk_n), .vstart_n(vstart_n)
  );

  lcd_inv_toggler #(
    .PIX_W(PIX_W), .LINE_W(LINE_W), .INV_CLK(INV_CLK),
    .FIRST_LINE(FIRST_LINE), .LAST_H_LINE(LAST_H_LINE), .EXTRA_LINE(EXTRA_LINE)
  ) u_inv (
    .clk(clk), .rst_n(rst_n), .pix(pix_cnt), .line(line_cnt),
    .fld(fld), .par(par), .par_ok(par_ok), .tgl_evt(tgl_evt), .hinv(hinv)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pdr <= 1'b0;
    else        pdr <= ~sleep_req;
  end
endmodule

// File: rtl/lcd_strobe_gen_chk.sv
module lcd_strobe_gen_chk #(
  parameter int PIX_W  = 9,
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_start,
  input logic              field_start,
  input logic              sleep_req,
  input logic              hstart,
  input logic              vclk_n,
  input logic              vstart_n,
  input logic              hinv,
  input logic              pdr,
  input logic              tgl_evt,
  input logic [PIX_W-1:0]  pix,
  input logic [LINE_W-1:0] line
);
  AST_PIX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (pix == '0));  // R1
  AST_FIELD_LINE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> (line == LINE_W'(1)));  // R5
  AST_VCLK_IN_HWIN: assert property (@(posedge clk) disable iff (!rst_n)
    !vclk_n |-> hstart);  // R3
  AST_VSTART_IN_HWIN: assert property (@(posedge clk) disable iff (!rst_n)
    !vstart_n |-> hstart);  // R4
  AST_INV_ONLY_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (hinv != $past(hinv)) |-> $past(tgl_evt));  // R6
  AST_SLEEP_PDR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> !pdr);  // R8
  AST_WAKE_PDR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_req |=> pdr);  // R8
endmodule

bind lcd_strobe_gen lcd_strobe_gen_chk #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .field_start(field_start),
  .sleep_req(sleep_req), .hstart(hstart), .vclk_n(vclk_n), .vstart_n(vstart_n),
  .hinv(hinv), .pdr(pdr), .tgl_evt(tgl_evt), .pix(pix_cnt), .line(line_cnt)
);

// File: tb/lcd_strobe_gen_test.sv
`timescale 1ns/1ps
module lcd_strobe_gen_test;
  localparam int LC = 64, PW = 8, INV = 40, LMAX = 1023;

  logic clk = 1'b0, rst_n = 1'b0;
  logic line_start = 1'b0, field_start = 1'b0, field_id = 1'b0, sleep_req = 1'b0;
  logic hstart, vclk_n, vstart_n, hinv, pdr;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  int m_pix = 0, m_line = 0, m_fld = 0, m_par = 0, m_par_ok = 0, m_hinv = 0, m_pdr = 0;
  int prev_hinv = 0, tog_cnt = 0, vs_cnt = 0, h_seen = 0;

  always #2 clk = ~clk;

  lcd_strobe_gen #(.LINE_CLKS(LC), .PULSE_W(PW), .INV_CLK(INV)) uut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .field_start(field_start),
    .field_id(field_id), .sleep_req(sleep_req), .hstart(hstart), .vclk_n(vclk_n),
    .vstart_n(vstart_n), .hinv(hinv), .pdr(pdr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference: integer state advanced at every rising edge.
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_pix = 0; m_line = 0; m_fld = 0; m_par = 0; m_par_ok = 0; m_hinv = 0; m_pdr = 0;
    end else begin
      if (m_pix == INV && ((m_line >= 22 && m_line <= 261) ||
          (m_line == 4 && m_par_ok == 1 && m_fld == m_par)))
        m_hinv = 1 - m_hinv;
      m_pdr = sleep_req ? 0 : 1;
      if (field_start) begin
        m_line = 1; m_fld = field_id;
        if (m_par_ok == 0) begin m_par = field_id; m_par_ok = 1; end
      end else if (line_start && m_line < LMAX) m_line = m_line + 1;
      if (line_start) m_pix = 0;
      else if (m_pix < LC - 1) m_pix = m_pix + 1;
    end
  end

  // Every-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic bit head = m_pix < PW;
      automatic int eh = (head && m_line >= 22 && m_line <= 261) ? 1 : 0;
      automatic int ev = (head && m_line >= 22 && m_line <= 260 && m_line % 2 == 0) ? 0 : 1;
      automatic int es = (head && m_line == 22) ? 0 : 1;
      chk(hstart == eh, "R2 hstart", int'(hstart), eh);
      chk(vclk_n == ev, "R3 vclk_n", int'(vclk_n), ev);
      chk(vstart_n == es, "R4 vstart_n", int'(vstart_n), es);
      chk(hinv == m_hinv, "R6/R7 hinv", int'(hinv), m_hinv);
      chk(pdr == m_pdr, "R8 pdr", int'(pdr), m_pdr);
      if (int'(hinv) != prev_hinv) tog_cnt++;
      prev_hinv = int'(hinv);
      if (!vstart_n) vs_cnt++;
      if (hstart) h_seen++;
    end
    if (cyc > 190000 && !done) begin
      done = 1;
      chk(0, "watchdog", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic one_line(input int len, input bit fs, input bit fid);
    @(negedge clk);
    line_start = 1'b1; field_start = fs; field_id = fid;
    @(negedge clk);
    line_start = 1'b0; field_start = 1'b0;
    repeat (len - 2) @(negedge clk);
  endtask

  task automatic one_field(input bit fid, input int nlines, input int exp_tog, input string req);
    tog_cnt = 0; vs_cnt = 0;
    one_line(LC, 1'b1, fid);
    for (int i = 1; i < nlines; i++) one_line(LC, 1'b0, fid);
    chk(vs_cnt == PW, "R4 one vstart pulse per field", vs_cnt, PW);
    chk(tog_cnt == exp_tog, req, tog_cnt, exp_tog);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(hstart == 1'b0, "R9 hstart reset", int'(hstart), 0);
    chk(vclk_n == 1'b1, "R9 vclk_n reset", int'(vclk_n), 1);
    chk(vstart_n == 1'b1, "R9 vstart_n reset", int'(vstart_n), 1);
    chk(hinv == 1'b0, "R9 hinv reset", int'(hinv), 0);
    chk(pdr == 1'b0, "R9 pdr reset", int'(pdr), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 R5: lines with no field strobe yet stay outside every window
    for (int i = 0; i < 3; i++) one_line(LC, 1'b0, 1'b0);
    chk(h_seen == 0, "R5 no strobes before field", h_seen, 0);
    // R7: first field captures parity 1 -> extra flip in id-1 fields only
    one_field(1'b1, 263, 241, "R7 flips in parity field");
    sleep_req = 1'b1;
    one_field(1'b0, 263, 240, "R6 flips in other field");
    sleep_req = 1'b0;
    one_field(1'b1, 263, 241, "R7 flips in parity field again");
    // R1: long line, pixel count holds at its last value
    one_line(3 * LC, 1'b0, 1'b0);
    // R5: line count saturates with no field strobe; windows stay shut
    h_seen = 0;
    for (int i = 0; i < 1100; i++) one_line(16, 1'b0, 1'b0);
    chk(h_seen == 0, "R5 saturated line count keeps strobes off", h_seen, 0);
    one_field(1'b0, 30, 9, "R6 short field flips");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule